// File: doc/BRIEF.md
# Capture/Compare Event Timer

An up-counting event timer whose count advances on ticks taken from one of several clock sources and then divided by a programmable prescaler. The count is compared with a reference value: on a match the timer either keeps counting or returns to zero. Each match also drives an output pin, either as a one-cycle low pulse or as a level toggle. A second input pin is synchronized and watched for a chosen edge, and on that edge the current count is copied into a capture register.

Reference and capture events set sticky flags. Software clears a flag by writing 1 to its bit. A pending flag raises a request that goes either to a DMA request line or to a shared interrupt line, depending on a route bit. Configuration uses simple register writes: mode (address 0), route (address 1), reference (address 2) and flag clear (address 3).

Top module: `evt_timer`

## Requirements
- R1: Mode bits [7:0] hold a prescale value P. The count advances once every P+1 ticks of the selected source, so P=0 gives a period of 1 and P=255 a period of 256 source ticks.
- R2: Mode bits [9:8] select the source. 00 stops counting. 01 ticks on every clock. 10 ticks once every 16 clocks. 11 ticks on each falling edge of `pin_i`, taken after a two-flop synchronizer. Rising edges of `pin_i` never advance the count.
- R3: Mode bits [11:10] select the capture edge: 00 none, 01 rising only, 10 falling only, 11 both. On a selected edge, `capture_o` takes the count and `flags_o[0]` sets. A pin change driven when the count reads c is captured as c+2 while the source is 01 and the prescale is 0.
- R4: Mode bit 12 selects the output style. At 0, `tmr_out_o` goes low for exactly one cycle after each match and is high otherwise. At 1, it inverts at each match. It is high after reset or disable.
- R5: A match occurs at a count tick whose incremented value equals the reference, and it sets `flags_o[1]`. With mode bit 13 at 1, the count goes to 0 at that tick, so the count never reads the reference. With mode bit 13 at 0, the count takes the reference value and keeps climbing.
- R6: Both flags stay set until a write to address 3 with the flag's bit set: bit 0 clears the capture flag and bit 1 clears the reference flag. Writing 0 to a bit leaves that flag alone.
- R7: The reference request is `flags_o[1]` AND mode bit 14. The capture request is `flags_o[0]`. When route bit 0 at address 1 is 1, the requests drive `dma_req_o[1]` (reference) and `dma_req_o[0]` (capture), and `irq_o` is 0. When the route bit is 0, `irq_o` is the OR of the requests and `dma_req_o` is 0.
- R8: Mode bit 15 enables the timer. A write that takes it from 1 to 0 zeroes the count, the capture register, both flags and the prescaler, and sets the output high. While the bit is 0 the count holds. Writes to other registers, and to other mode fields, still take effect.
- R9: After reset all registers are zero, the count and capture read 0, no flag or request is set, and `tmr_out_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 mode, 1 route, 2 reference, 3 flag clear |
| wr_data_i | input | DATA_W | Write data |
| pin_i | input | 1 | External pin used for capture and as a count source |
| count_o | output | DATA_W | Current count |
| capture_o | output | DATA_W | Last captured count |
| flags_o | output | 2 | Sticky flags: bit 1 reference, bit 0 capture |
| dma_req_o | output | 2 | DMA requests: bit 1 reference, bit 0 capture |
| irq_o | output | 1 | Interrupt request |
| tmr_out_o | output | 1 | Match output pin |

## Verification
The prescale period is measured as the number of clocks between count changes. It is measured for prescale values 0, 1, 3, 7 and 255 on the system source, and for two values on the divide-by-16 source; this separates the P+1 divide from an off-by-one error and from the source choice. Pin-clocked counting uses trains of full pulses, so the count would double if rising edges were also counted. Each capture-edge mode is tried with a rising edge and then with a falling edge on a frozen count, which sorts the four modes apart. A live capture pins down the two-cycle synchronizer delay. Restart and free-run runs, followed cycle by cycle, show whether the count resets at the match or runs through it. The pulse and toggle runs check the spacing and width of each output transition.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int MODE_W = 16;
  localparam int PS_W   = 8;
  localparam int EN_BIT = 15;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_ROUTE = 2'd1;
  localparam logic [1:0] ADDR_REF   = 2'd2;
  localparam logic [1:0] ADDR_CLR   = 2'd3;

  typedef enum logic [1:0] {SRC_OFF, SRC_SYS, SRC_DIV, SRC_PIN} clk_src_e;
  typedef enum logic [1:0] {CAP_NONE, CAP_RISE, CAP_FALL, CAP_BOTH} cap_edge_e;

  typedef struct packed {
    logic            en;       // [15]
    logic            ref_en;   // [14]
    logic            restart;  // [13]
    logic            toggle;   // [12]
    cap_edge_e       cap;      // [11:10]
    clk_src_e        src;      // [9:8]
    logic [PS_W-1:0] ps;       // [7:0]
  } mode_t;
endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/evt_tick_gen.sv
module evt_tick_gen
  import evt_timer_pkg::*;
#(
  parameter int PW    = PS_W,
  parameter int DIV_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  clk_src_e      src_i,
  input  logic [PW-1:0] ps_i,
  input  logic          pin_fall_i,
  output logic          tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [PW-1:0]    pcnt_q;
  logic             src_tick;
  logic             wrap;

  // free-running divider, not tied to the timer enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + DIV_W'(1);
  end

  always_comb begin
    unique case (src_i)
      SRC_SYS: src_tick = 1'b1;
      SRC_DIV: src_tick = (div_q == '1);
      SRC_PIN: src_tick = pin_fall_i;
      default: src_tick = 1'b0;
    endcase
  end

  // >= keeps a lowered prescale from wrapping the counter
  assign wrap = (pcnt_q >= ps_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pcnt_q <= '0;
    else if (!en_i)    pcnt_q <= '0;
    else if (src_tick) pcnt_q <= wrap ? '0 : pcnt_q + PW'(1);
  end

  assign tick_o = en_i & src_tick & wrap;
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clear_i,
  input  logic         restart_i,
  input  logic         toggle_i,
  input  logic [W-1:0] ref_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o,
  output logic         out_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] nxt;
  logic         out_q;

  assign nxt     = cnt_q + W'(1);
  assign match_o = tick_i & (nxt == ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (clear_i) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      if (tick_i) cnt_q <= (match_o && restart_i) ? '0 : nxt;
      if (match_o)        out_q <= toggle_i ? ~out_q : 1'b0;
      else if (!toggle_i) out_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;
endmodule

// File: rtl/evt_capture_unit.sv
module evt_capture_unit
  import evt_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clear_i,
  input  cap_edge_e    edge_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cap_o,
  output logic         hit_o
);
  logic [W-1:0] cap_q;
  logic         sel;

  always_comb begin
    unique case (edge_i)
      CAP_RISE: sel = rise_i;
      CAP_FALL: sel = fall_i;
      CAP_BOTH: sel = rise_i | fall_i;
      default:  sel = 1'b0;
    endcase
  end

  assign hit_o = en_i & sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cap_q <= '0;
    else if (clear_i) cap_q <= '0;
    else if (hit_o)   cap_q <= cnt_i;
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pin_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] capture_o,
  output logic [1:0]        flags_o,
  output logic [1:0]        dma_req_o,
  output logic              irq_o,
  output logic              tmr_out_o
);
  localparam int NEV = 2;

  mode_t             mode_q;
  logic              dma_sel_q;
  logic [DATA_W-1:0] ref_q;
  logic [NEV-1:0]    flag_q;
  logic [NEV-1:0]    set_ev;
  logic [NEV-1:0]    req;
  logic              wr_mode, wr_route, wr_ref, wr_clr, dis;
  logic              pin_rise, pin_fall, tick, ref_hit, cap_hit;

  assign wr_mode  = wr_en_i && (wr_addr_i == ADDR_MODE);
  assign wr_route = wr_en_i && (wr_addr_i == ADDR_ROUTE);
  assign wr_ref   = wr_en_i && (wr_addr_i == ADDR_REF);
  assign wr_clr   = wr_en_i && (wr_addr_i == ADDR_CLR);
  assign dis      = wr_mode && mode_q.en && !wr_data_i[EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      dma_sel_q <= 1'b0;
      ref_q     <= '0;
    end else begin
      if (wr_mode)  mode_q    <= mode_t'(wr_data_i[MODE_W-1:0]);
      if (wr_route) dma_sel_q <= wr_data_i[0];
      if (wr_ref)   ref_q     <= wr_data_i;
    end
  end

  evt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  evt_tick_gen #(.PW(PS_W), .DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .en_i(mode_q.en), .src_i(mode_q.src), .ps_i(mode_q.ps),
    .pin_fall_i(pin_fall), .tick_o(tick)
  );

  evt_count_core #(.W(DATA_W)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .clear_i(dis), .restart_i(mode_q.restart),
    .toggle_i(mode_q.toggle), .ref_i(ref_q), .cnt_o(count_o), .match_o(ref_hit),
    .out_o(tmr_out_o)
  );

  evt_capture_unit #(.W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .en_i(mode_q.en), .clear_i(dis), .edge_i(mode_q.cap),
    .rise_i(pin_rise), .fall_i(pin_fall), .cnt_i(count_o), .cap_o(capture_o),
    .hit_o(cap_hit)
  );

  assign set_ev = {ref_hit, cap_hit};

  for (genvar i = 0; i < NEV; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  flag_q[i] <= 1'b0;
      else if (dis) flag_q[i] <= 1'b0;
      else          flag_q[i] <= set_ev[i] | (flag_q[i] & ~(wr_clr & wr_data_i[i]));
    end
  end

  assign req       = {flag_q[1] & mode_q.ref_en, flag_q[0]};
  assign flags_o   = flag_q;
  assign dma_req_o = dma_sel_q ? req : '0;
  assign irq_o     = ~dma_sel_q & (|req);
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              ref_en_i,
  input logic              restart_i,
  input logic              dma_sel_i,
  input logic [DATA_W-1:0] ref_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] count_o,
  input logic [1:0]        flags_o,
  input logic [1:0]        dma_req_o,
  input logic              irq_o,
  input logic              tmr_out_o
);
  logic clr0_wr, mode_wr;
  assign clr0_wr = wr_en_i && (wr_addr_i == ADDR_CLR) && wr_data_i[0];
  assign mode_wr = wr_en_i && (wr_addr_i == ADDR_MODE);

  // R8
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> $stable(count_o));

  // R4
  disabled_out_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> tmr_out_o);

  // R5
  restart_skips_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && $past(restart_i) && $stable(ref_i) && ref_i != '0 &&
     $past(count_o != ref_i)) |-> (count_o != ref_i));

  // R6
  cap_flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[0] && !clr0_wr && !mode_wr) |=> flags_o[0]);

  // R7
  route_dma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_sel_i |-> !irq_o);

  // R7
  route_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_sel_i |-> (dma_req_o == 2'b00));

  // R7
  ref_req_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_en_i |-> !dma_req_o[1]);
endmodule

bind evt_timer evt_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mode_q.en), .ref_en_i(mode_q.ref_en),
  .restart_i(mode_q.restart), .dma_sel_i(dma_sel_q), .ref_i(ref_q),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .count_o(count_o), .flags_o(flags_o), .dma_req_o(dma_req_o), .irq_o(irq_o),
  .tmr_out_o(tmr_out_o)
);

// File: tb/evt_timer_test.sv
module evt_timer_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         pin = 1'b0;
  logic [W-1:0] count, capture;
  logic [1:0]   flags, dma_req;
  logic         irq, tout;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pin_i(pin), .count_o(count), .capture_o(capture),
    .flags_o(flags), .dma_req_o(dma_req), .irq_o(irq), .tmr_out_o(tout)
  );

  function automatic logic [15:0] md(bit en, bit ren, bit rs, bit tg,
                                     int cap, int src, int ps);
    md = {en, ren, rs, tg, 2'(cap), 2'(src), 8'(ps)};
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic period(output int p);
    logic [W-1:0] last;
    int n;
    last = count; n = 0;
    while (count == last && n < 2000) begin @(negedge clk); n++; end
    last = count; n = 0;
    while (count == last && n < 2000) begin @(negedge clk); n++; end
    p = n;
  endtask

  task automatic pulses(int n, int hi, int lo);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; idle(hi);
      pin = 1'b0; idle(lo);
    end
  endtask

  task automatic reset_all();
    wr(2'd0, '0);
    wr(2'd3, 16'h3);
    wr(2'd1, '0);
  endtask

  initial begin
    int p, v, c, errs, lows, last_i;
    logic last_o;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R9 reset state
    chk("R9 count", count, 0);
    chk("R9 capture", capture, 0);
    chk("R9 flags", flags, 0);
    chk("R9 dma", dma_req, 0);
    chk("R9 irq", irq, 0);
    chk("R9 out", tout, 1);

    // R1 prescale periods on system source
    wr(2'd2, 16'hFFFF);
    foreach (p_list[k]) begin
      wr(2'd0, md(1, 0, 0, 0, 0, 1, p_list[k]));
      period(p);
      chk("R1 prescale period", p, p_list[k] + 1);
      wr(2'd0, '0);
    end

    // R2 divide-by-16 source
    wr(2'd0, md(1, 0, 0, 0, 0, 2, 0));
    period(p);
    chk("R2 div16 period", p, 16);
    wr(2'd0, '0);
    wr(2'd0, md(1, 0, 0, 0, 0, 2, 2));
    period(p);
    chk("R2 div16 ps2 period", p, 48);
    wr(2'd0, '0);

    // R2 stopped source holds count
    wr(2'd0, md(1, 0, 0, 0, 0, 1, 0));
    idle(20);
    wr(2'd0, md(1, 0, 0, 0, 0, 0, 0));
    v = count;
    idle(50);
    chk("R2 stop holds", count, v);
    wr(2'd0, '0);

    // R2 pin falling edges only
    wr(2'd0, md(1, 0, 0, 0, 0, 3, 0));
    pulses(7, 3, 3);
    idle(5);
    chk("R2 pin edges ps0", count, 7);
    wr(2'd0, '0);
    wr(2'd0, md(1, 0, 0, 0, 0, 3, 1));
    pulses(8, 2, 4);
    idle(5);
    chk("R2 pin edges ps1", count, 4);
    wr(2'd0, '0);

    // R3 edge modes on a frozen count
    wr(2'd0, md(1, 0, 0, 0, 0, 1, 0));
    idle(20);
    wr(2'd0, md(1, 0, 0, 0, 0, 0, 0));
    v = count;
    for (int m = 0; m < 4; m++) begin
      wr(2'd0, md(1, 0, 0, 0, m, 0, 0));
      wr(2'd3, 16'h3);
      pin = 1'b1; idle(5);
      chk("R3 rise flag", flags[0], (m == 1 || m == 3) ? 1 : 0);
      if (m == 1 || m == 3) chk("R3 rise value", capture, v);
      wr(2'd3, 16'h1);
      pin = 1'b0; idle(5);
      chk("R3 fall flag", flags[0], (m >= 2) ? 1 : 0);
      if (m >= 2) chk("R3 fall value", capture, v);
    end
    wr(2'd0, '0);

    // R3 live capture latency
    wr(2'd0, md(1, 0, 0, 0, 1, 1, 0));
    idle(10);
    @(negedge clk);
    c = count; pin = 1'b1;
    idle(5);
    chk("R3 live capture", capture, c + 2);
    pin = 1'b0; idle(4);

    // R6 sticky flag and selective clear
    idle(20);
    chk("R6 flag sticky", flags[0], 1);
    wr(2'd3, 16'h2);
    chk("R6 other bit no clear", flags[0], 1);

    // R7 routing of capture request
    chk("R7 irq route", irq, 1);
    chk("R7 irq route dma", dma_req, 0);
    wr(2'd1, 16'h1);
    chk("R7 dma route", dma_req, 1);
    chk("R7 dma route irq", irq, 0);
    wr(2'd3, 16'h1);
    chk("R6 clear", flags[0], 0);
    wr(2'd0, '0);

    // R5 restart at reference
    wr(2'd1, '0);
    wr(2'd2, 16'd5);
    wr(2'd0, md(1, 0, 1, 0, 0, 1, 0));
    idle(2);
    errs = 0; v = 0;
    for (int i = 0; i < 30; i++) begin
      c = count;
      @(negedge clk);
      if (count != (c + 1) % 5) errs++;
      if (count > v) v = count;
    end
    chk("R5 restart sequence", errs, 0);
    chk("R5 restart max", v, 4);
    chk("R5 restart flag", flags[1], 1);
    chk("R7 ref disabled no irq", irq, 0);
    wr(2'd0, md(1, 1, 1, 0, 0, 1, 0));
    chk("R7 ref enabled irq", irq, 1);
    wr(2'd0, '0);

    // R5 free-run through reference
    wr(2'd0, md(1, 0, 0, 0, 0, 1, 0));
    errs = 0;
    for (int i = 0; i < 12; i++) begin
      c = count;
      @(negedge clk);
      if (count != c + 1) errs++;
    end
    chk("R5 freerun sequence", errs, 0);
    chk("R5 freerun passes ref", (count > 5) ? 1 : 0, 1);
    chk("R5 freerun flag", flags[1], 1);
    wr(2'd0, '0);

    // R4 pulse output
    wr(2'd0, md(1, 0, 1, 0, 0, 1, 0));
    idle(3);
    errs = 0; lows = 0; last_i = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!tout) begin
        lows++;
        if (count != 0) errs++;
        if (last_i >= 0 && i - last_i != 5) errs++;
        last_i = i;
      end
    end
    chk("R4 pulse spacing", errs, 0);
    chk("R4 pulse count", lows, 8);
    wr(2'd0, '0);
    chk("R4 idle high", tout, 1);

    // R4 toggle output
    wr(2'd0, md(1, 0, 1, 1, 0, 1, 0));
    idle(3);
    errs = 0; lows = 0; last_i = -1; last_o = tout;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tout != last_o) begin
        lows++;
        if (last_i >= 0 && i - last_i != 5) errs++;
        last_i = i;
      end
      last_o = tout;
    end
    chk("R4 toggle spacing", errs, 0);
    chk("R4 toggle count", lows, 8);

    // R8 disable clears and holds, writes while disabled apply
    wr(2'd0, md(1, 0, 0, 0, 1, 1, 0));
    pin = 1'b1; idle(6); pin = 1'b0;
    wr(2'd0, md(0, 0, 0, 0, 0, 1, 4));
    chk("R8 count cleared", count, 0);
    chk("R8 capture cleared", capture, 0);
    chk("R8 flags cleared", flags, 0);
    chk("R8 out high", tout, 1);
    idle(50);
    chk("R8 hold", count, 0);
    wr(2'd0, md(1, 0, 0, 0, 0, 1, 4));
    period(p);
    chk("R8 prescale written while off", p, 5);
    wr(2'd0, '0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int p_list[5] = '{0, 1, 3, 7, 255};

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule